// File: doc/BRIEF.md
# Coprocessor Data Register Transfer Unit

This block holds the 32-entry data register file of a geometry coprocessor, together with its screen-distance control register at index 26. It performs the move-to and move-from transfers between the host processor and those registers. Each read passes through a per-index view: some indices come back sign-extended from their low half, some zero-extended, one returns the newest screen coordinate, and two return a packed 5:5:5 colour built from saturated interpolation values.

Writes carry side effects as well. A write to index 15 pushes a three-deep screen coordinate FIFO, held at indices 12 (oldest), 13 and 14 (newest). A write to index 28 stores the raw word and also unpacks its three 5-bit colour fields into the interpolation registers at indices 9, 10 and 11. The control register keeps a sign-extended copy of the low 16 bits it receives, and the block presents the same 16 bits as an unsigned distance value for the arithmetic datapath.

There is no sequencing: a write takes effect at the clock edge where its strobe is sampled, and reads are combinational from the current register contents.

Top module: `cop_xfer_unit`

## Requirements
- R1: Reading index 1, 3, 5, 8, 9, 10 or 11 returns the stored low 16 bits sign-extended to 32 bits (bit 15 copied into bits 31:16).
- R2: Reading index 7, 16, 17, 18 or 19 returns the stored low 16 bits with bits 31:16 zero.
- R3: Reading index 15 returns the newest FIFO entry, which is the word held at index 14.
- R4: Reading index 28 or 29 returns a packed colour with bits 31:15 zero: bits 4:0 from index 9, bits 9:5 from index 10 and bits 14:10 from index 11, each field being the signed low 16 bits of its source shifted right by 7 and saturated to 0..31 (negative gives 0, 0x0F80 and above give 31).
- R5: A data write to index 15 moves index 13 into 12 and index 14 into 13 and stores the written word at 14, in the same clock edge.
- R6: A data write to index 28 stores the full word at 28 and sets index 9 to bits 4:0 of the word shifted left by 7, index 10 to bits 9:5 shifted left by 7, and index 11 to bits 14:10 shifted left by 7, with all other bits zero.
- R7: A control write with index 26 stores the written low 16 bits sign-extended to 32 bits; `ctrl_rdata` shows that stored word, and `h_dist` shows its low 16 bits as an unsigned value.
- R8: Every other data index (0, 2, 4, 6, 12, 13, 14 written directly, and 20 to 27, 30, 31) stores the full 32-bit word and returns it unchanged.
- R9: After reset every data read and `ctrl_rdata` return zero.
- R10: A control write whose index is not 26 leaves `ctrl_rdata` and `h_dist` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 5 | Register index for reads and writes |
| data_we | input | 1 | Data register write strobe |
| ctrl_we | input | 1 | Control register write strobe |
| wdata | input | 32 | Write data |
| data_rdata | output | 32 | Combinational read of the data register at `addr` |
| ctrl_rdata | output | 32 | Stored word of control register 26 |
| h_dist | output | 16 | Unsigned distance value from control register 26 |

## Verification
The checks assume the host never raises `data_we` and `ctrl_we` in the same cycle, and that `addr` and `wdata` are stable around each sampled edge; the stimulus drives all inputs on the falling edge and raises at most one strobe per operation. Random values are mixed with short signed values near the saturation thresholds so the packed read sees negative, in-range and clamped fields, and a share of control writes deliberately target indices other than 26.

// File: rtl/cop_xfer_pkg.sv
package cop_xfer_pkg;

    localparam int NREG   = 32;
    localparam int DW     = 32;
    localparam int AW     = $clog2(NREG);
    localparam int HALF   = DW / 2;
    localparam int FLD    = 5;
    localparam int FSHIFT = 7;

    // Indices whose behaviour is fixed by the transfer rules
    localparam logic [AW-1:0] IDX_IR1    = AW'(9);
    localparam logic [AW-1:0] IDX_IR2    = AW'(10);
    localparam logic [AW-1:0] IDX_IR3    = AW'(11);
    localparam logic [AW-1:0] IDX_SXY0   = AW'(12);
    localparam logic [AW-1:0] IDX_SXY1   = AW'(13);
    localparam logic [AW-1:0] IDX_SXY2   = AW'(14);
    localparam logic [AW-1:0] IDX_SXYP   = AW'(15);
    localparam logic [AW-1:0] IDX_CPACK  = AW'(28);
    localparam logic [AW-1:0] IDX_CPACKR = AW'(29);
    localparam logic [AW-1:0] IDX_HDIST  = AW'(26);

    typedef enum logic [2:0] {
        VIEW_RAW,
        VIEW_SEXT,
        VIEW_ZEXT,
        VIEW_FIFO,
        VIEW_PACK
    } read_view_e;

    function automatic read_view_e view_of(input logic [AW-1:0] idx);
        read_view_e v;
        unique case (idx)
            AW'(1), AW'(3), AW'(5), AW'(8),
            AW'(9), AW'(10), AW'(11):           v = VIEW_SEXT;
            AW'(7), AW'(16), AW'(17),
            AW'(18), AW'(19):                   v = VIEW_ZEXT;
            IDX_SXYP:                           v = VIEW_FIFO;
            IDX_CPACK, IDX_CPACKR:              v = VIEW_PACK;
            default:                            v = VIEW_RAW;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cop_data_store.sv
module cop_data_store
    import cop_xfer_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] regs_o [NREG]
);

    localparam int PADW = DW - FLD - FSHIFT;

    logic [DW-1:0] q   [NREG];
    logic [DW-1:0] nxt [NREG];

    // colour fields of the written word, already placed at the IR scale
    logic [DW-1:0] unpack [3];
    for (genvar f = 0; f < 3; f++) begin : g_unpack
        assign unpack[f] = {{PADW{1'b0}}, wdata[f*FLD +: FLD], {FSHIFT{1'b0}}};
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [AW-1:0] ME = AW'(i);

        always_comb begin
            nxt[i] = q[i];
            if (addr == ME && ME != IDX_SXYP) begin
                nxt[i] = wdata;
            end
            if (addr == IDX_SXYP) begin
                if (ME == IDX_SXY0) nxt[i] = q[IDX_SXY1];
                if (ME == IDX_SXY1) nxt[i] = q[IDX_SXY2];
                if (ME == IDX_SXY2) nxt[i] = wdata;
            end
            if (addr == IDX_CPACK) begin
                if (ME == IDX_IR1) nxt[i] = unpack[0];
                if (ME == IDX_IR2) nxt[i] = unpack[1];
                if (ME == IDX_IR3) nxt[i] = unpack[2];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[i] <= '0;
            end else if (we) begin
                q[i] <= nxt[i];
            end
        end

        assign regs_o[i] = q[i];
    end

endmodule

// File: rtl/cop_read_view.sv
module cop_read_view
    import cop_xfer_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] regs   [NREG],
    output logic [DW-1:0] rdata
);

    localparam int PACKW = 3 * FLD;

    function automatic logic [FLD-1:0] sat_field(input logic [HALF-1:0] v);
        logic [FLD-1:0] r;
        if (v[HALF-1]) begin
            r = '0;
        end else if (|v[HALF-2:FSHIFT+FLD]) begin
            r = '1;
        end else begin
            r = v[FSHIFT +: FLD];
        end
        return r;
    endfunction

    logic [PACKW-1:0] packed_c;
    assign packed_c = {sat_field(regs[IDX_IR3][HALF-1:0]),
                       sat_field(regs[IDX_IR2][HALF-1:0]),
                       sat_field(regs[IDX_IR1][HALF-1:0])};

    read_view_e    view;
    logic [DW-1:0] sel;

    assign view = view_of(addr);
    assign sel  = regs[addr];

    always_comb begin
        unique case (view)
            VIEW_SEXT: rdata = {{(DW-HALF){sel[HALF-1]}}, sel[HALF-1:0]};
            VIEW_ZEXT: rdata = {{(DW-HALF){1'b0}}, sel[HALF-1:0]};
            VIEW_FIFO: rdata = regs[IDX_SXY2];
            VIEW_PACK: rdata = {{(DW-PACKW){1'b0}}, packed_c};
            default:   rdata = sel;
        endcase
    end

endmodule

// File: rtl/cop_hdist_reg.sv
module cop_hdist_reg
    import cop_xfer_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   addr,
    input  logic [HALF-1:0] wlow,
    output logic [DW-1:0]   word_o,
    output logic [HALF-1:0] h_o
);

    logic [DW-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we && addr == IDX_HDIST) begin
            q <= {{(DW-HALF){wlow[HALF-1]}}, wlow};
        end
    end

    assign word_o = q;
    assign h_o    = q[HALF-1:0];

endmodule

// File: rtl/cop_xfer_unit.sv
module cop_xfer_unit
    import cop_xfer_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [4:0]    addr,
    input  logic          data_we,
    input  logic          ctrl_we,
    input  logic [31:0]   wdata,
    output logic [31:0]   data_rdata,
    output logic [31:0]   ctrl_rdata,
    output logic [15:0]   h_dist
);

    logic [DW-1:0] regs_w [NREG];

    cop_data_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (data_we),
        .addr   (addr),
        .wdata  (wdata),
        .regs_o (regs_w)
    );

    cop_read_view u_view (
        .addr  (addr),
        .regs  (regs_w),
        .rdata (data_rdata)
    );

    cop_hdist_reg u_hdist (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ctrl_we),
        .addr   (addr),
        .wlow   (wdata[HALF-1:0]),
        .word_o (ctrl_rdata),
        .h_o    (h_dist)
    );

endmodule

// File: rtl/cop_xfer_chk.sv
module cop_xfer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  addr,
    input logic        data_we,
    input logic        ctrl_we,
    input logic [31:0] wdata,
    input logic [31:0] data_rdata,
    input logic [31:0] ctrl_rdata,
    input logic [15:0] h_dist,
    input logic [31:0] sxy0,
    input logic [31:0] sxy1,
    input logic [31:0] sxy2,
    input logic [31:0] ir1,
    input logic [31:0] raw28
);

    logic sext_idx, zext_idx;
    assign sext_idx = addr inside {5'd1, 5'd3, 5'd5, 5'd8, 5'd9, 5'd10, 5'd11};
    assign zext_idx = addr inside {5'd7, 5'd16, 5'd17, 5'd18, 5'd19};

    AST_SIGN_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        sext_idx |-> data_rdata[31:16] == {16{data_rdata[15]}}); // R1

    AST_ZERO_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        zext_idx |-> data_rdata[31:16] == 16'h0); // R2

    AST_FIFO_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        addr == 5'd15 |-> data_rdata == sxy2); // R3

    AST_PACK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 5'd28 || addr == 5'd29) |-> data_rdata[31:15] == 17'h0); // R4

    AST_FIFO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && addr == 5'd15) |=>
            sxy0 == $past(sxy1) && sxy1 == $past(sxy2) && sxy2 == $past(wdata)); // R5

    AST_COLOUR_UNPACK: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && addr == 5'd28) |=>
            ir1 == {20'h0, $past(wdata[4:0]), 7'h0} && raw28 == $past(wdata)); // R6

    AST_HDIST_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[31:16] == {16{ctrl_rdata[15]}} && h_dist == ctrl_rdata[15:0]); // R7

    AST_CTRL_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && addr != 5'd26) |=> $stable(ctrl_rdata)); // R10

endmodule

bind cop_xfer_unit cop_xfer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .data_we    (data_we),
    .ctrl_we    (ctrl_we),
    .wdata      (wdata),
    .data_rdata (data_rdata),
    .ctrl_rdata (ctrl_rdata),
    .h_dist     (h_dist),
    .sxy0       (regs_w[12]),
    .sxy1       (regs_w[13]),
    .sxy2       (regs_w[14]),
    .ir1        (regs_w[9]),
    .raw28      (regs_w[28])
);

// File: tb/sim_cop_xfer_unit.sv
module sim_cop_xfer_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        data_we = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] data_rdata, ctrl_rdata;
    logic [15:0] h_dist;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] mdl [32];
    logic [31:0] mctrl;

    always #(CLK_PERIOD/2) clk = ~clk;

    cop_xfer_unit u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .data_we(data_we),
        .ctrl_we(ctrl_we), .wdata(wdata), .data_rdata(data_rdata),
        .ctrl_rdata(ctrl_rdata), .h_dist(h_dist)
    );

    // saturated 5-bit field from a signed 16-bit interpolation value (R4)
    function automatic int field_of(input logic [31:0] r);
        int v;
        v = int'($signed(r[15:0]));
        if (v < 0) return 0;
        if (v >= 32 * 128) return 31;
        return v / 128;
    endfunction

    function automatic logic [31:0] exp_read(input int a);
        logic [31:0] w;
        w = mdl[a];
        if (a inside {1, 3, 5, 8, 9, 10, 11}) return {{16{w[15]}}, w[15:0]};
        if (a inside {7, 16, 17, 18, 19})      return {16'h0, w[15:0]};
        if (a == 15)                           return mdl[14];
        if (a == 28 || a == 29)
            return 32'(field_of(mdl[9]) + 32 * field_of(mdl[10]) + 1024 * field_of(mdl[11]));
        return w;
    endfunction

    function automatic string tag_of(input int a);
        if (a inside {1, 3, 5, 8, 9, 10, 11}) return "R1";
        if (a inside {7, 16, 17, 18, 19})      return "R2";
        if (a == 15)                           return "R3";
        if (a == 28 || a == 29)                return "R4";
        return "R8";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic data_write(input int a, input logic [31:0] v);
        @(negedge clk);
        addr = 5'(a); wdata = v; data_we = 1'b1;
        @(negedge clk);
        data_we = 1'b0;
        if (a == 15) begin                       // R5
            mdl[12] = mdl[13]; mdl[13] = mdl[14]; mdl[14] = v;
        end else begin
            mdl[a] = v;
            if (a == 28) begin                   // R6
                mdl[9]  = {20'h0, v[4:0],   7'h0};
                mdl[10] = {20'h0, v[9:5],   7'h0};
                mdl[11] = {20'h0, v[14:10], 7'h0};
            end
        end
    endtask

    task automatic ctrl_write(input int a, input logic [31:0] v);
        @(negedge clk);
        addr = 5'(a); wdata = v; ctrl_we = 1'b1;
        @(negedge clk);
        ctrl_we = 1'b0;
        if (a == 26) mctrl = {{16{v[15]}}, v[15:0]};   // R7; other index: R10
    endtask

    task automatic read_check(input int a);
        @(negedge clk);
        addr = 5'(a);
        #1;
        check(tag_of(a), data_rdata, exp_read(a));
    endtask

    task automatic ctrl_check(input string req);
        #1;
        check(req, ctrl_rdata, mctrl);
        check(req, {16'h0, h_dist}, {16'h0, mctrl[15:0]});
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        mctrl = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R9: reset state
        for (int a = 0; a < 32; a++) begin
            @(negedge clk); addr = 5'(a); #1;
            check("R9", data_rdata, 32'h0);
        end
        ctrl_check("R9");

        // R6/R4: full colour word gives max IR and packs back to 0x7FFF
        data_write(28, 32'hABCD_FFFF);
        read_check(9); read_check(10); read_check(11);
        read_check(28); read_check(29);
        // R4 saturation corners
        data_write(9,  32'h0000_8000);   // negative -> 0
        data_write(10, 32'h0000_1000);   // too big -> 31
        data_write(11, 32'h0000_0F7F);   // -> 30
        read_check(28);
        data_write(9,  32'h0000_0F80);   // exactly 31
        data_write(10, 32'hFFFF_FFFF);   // -1 -> 0
        data_write(11, 32'h1234_007F);   // -> 0
        read_check(29);
        // R5/R3: FIFO pushes
        data_write(15, 32'h1111_1111);
        data_write(15, 32'h2222_2222);
        data_write(15, 32'h3333_3333);
        read_check(12); read_check(13); read_check(14); read_check(15);
        // R8: direct write into a FIFO slot
        data_write(13, 32'hDEAD_BEEF);
        read_check(13); read_check(15);
        // R7: control sign extension, R10: other index ignored
        ctrl_write(26, 32'h0000_8000); ctrl_check("R7");
        ctrl_write(26, 32'hFFFF_7FFF); ctrl_check("R7");
        ctrl_write(5,  32'h0000_FFFF); ctrl_check("R10");
        // R1/R2: extension on a negative low half
        data_write(3,  32'h0000_9000); read_check(3);
        data_write(17, 32'hFFFF_9000); read_check(17);

        // random mix
        for (int k = 0; k < 1500; k++) begin
            int op, a;
            logic [31:0] v;
            op = int'($urandom % 5);
            a  = int'($urandom % 32);
            if ($urandom % 2 == 0) v = $urandom;
            else v = {{19{$urandom % 2 == 0}}, 13'($urandom)};
            case (op)
                0, 1: data_write(a, v);
                2: begin
                    ctrl_write(($urandom % 2 == 0) ? 26 : a, v);
                    ctrl_check((a == 26) ? "R7" : "R10");
                end
                default: read_check(a);
            endcase
        end
        for (int a = 0; a < 32; a++) read_check(a);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule